// File: doc/BRIEF.md
# Predicated Commit Gate

This block adds guarded execution to a simple in-order pipeline without touching fetch. A compare operation writes one boolean predicate bit. Every later operation carries a guard flag. A guarded operation still flows through every stage and takes its slot, so both arms of a condition run one after the other. At the commit point the gate cancels the architectural effects of any guarded operation whose predicate is false. Those effects are the register-file write and the memory store. The pipeline therefore never has to redirect on a condition and has no control hazard to resolve.

The gate sits beside the writeback stage. The predicate write port comes from the compare operation. The commit-stage operation presents its valid bit, its guard flag and its two write requests. The gate returns the two gated write enables. A predicate written in a cycle is bypassed to the operation committing in that same cycle. A saturating count of cancelled commits is brought out for checking.

Top module: `predicated_commit_gate`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and right after it, `pred_state` is 0 (false) and `squash_count` is 0.
- R2: At a rising clock edge with `pred_wr_en` high, `pred_state` takes `pred_wr_val`. With `pred_wr_en` low, `pred_state` holds its value.
- R3: For a valid, unguarded commit (`wb_valid`=1, `wb_guard`=0), `rf_we` equals `wb_rf_req` and `st_we` equals `wb_st_req` in the same cycle, whatever the predicate.
- R4: For a valid, guarded commit, `rf_we` is high only when `wb_rf_req` is high and the effective predicate is true.
- R5: For a valid, guarded commit, `st_we` is high only when `wb_st_req` is high and the effective predicate is true.
- R6: The effective predicate is `pred_wr_val` in any cycle where `pred_wr_en` is high, and `pred_state` otherwise. A compare and a guarded commit in the same cycle therefore see the new value.
- R7: When `wb_valid` is low, `rf_we` and `st_we` are both 0, whatever the other inputs are.
- R8: `squash_count` rises by exactly one at each clock edge where a valid, guarded commit with at least one write request meets a false effective predicate. In every other cycle it holds its value. One commit counts once, even when both of its writes are cancelled.
- R9: `squash_count` saturates at 2^CNT_W-1 and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_wr_en | input | 1 | The compare operation writes the predicate this cycle |
| pred_wr_val | input | 1 | Predicate value being written |
| wb_valid | input | 1 | The commit stage holds a real operation |
| wb_guard | input | 1 | The commit-stage operation is guarded by the predicate |
| wb_rf_req | input | 1 | The operation requests a register-file write |
| wb_st_req | input | 1 | The operation requests a memory store |
| rf_we | output | 1 | Gated register-file write enable |
| st_we | output | 1 | Gated memory write enable |
| pred_state | output | 1 | Architectural predicate bit |
| squash_count | output | CNT_W | Saturating count of cancelled commits |

## Verification
The assertions check on every cycle that idle slots never write and that unguarded operations pass their requests unchanged. They also check that guarded writes follow the effective predicate, that the bypass selects the freshly written value, that the predicate loads and holds correctly, and that the counter steps and saturates. Only the bench's scenarios can show the reset values. They also show that a compare and a guarded commit in the same cycle behave as a then/else pair across many random mixes, and that a long run of cancelled commits stops exactly at the saturation value.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  // Index of each architectural write kind handled by the gate
  typedef enum int unsigned {
    WR_RF = 0,
    WR_ST = 1
  } wr_kind_e;

  localparam int unsigned NUM_WR = 2;

  // Predicate seen by the commit stage: new value wins over stored one
  function automatic logic eff_pred(input logic wr_en, input logic wr_val,
                                    input logic stored);
    return wr_en ? wr_val : stored;
  endfunction

  // Whether one write request may commit
  function automatic logic commit_ok(input logic valid, input logic guard,
                                     input logic pred, input logic req);
    return valid & req & (~guard | pred);
  endfunction

  // Whether one write request is cancelled by the predicate
  function automatic logic cancelled(input logic valid, input logic guard,
                                     input logic pred, input logic req);
    return valid & req & guard & ~pred;
  endfunction

endpackage

// File: rtl/pcg_pred_reg.sv
module pcg_pred_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic pred_q,
  output logic pred_eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pred_q <= 1'b0;
    else if (wr_en) pred_q <= wr_val;
  end

  // Same-cycle bypass toward the commit stage
  assign pred_eff = pcg_pkg::eff_pred(wr_en, wr_val, pred_q);
endmodule

// File: rtl/pcg_commit_lane.sv
module pcg_commit_lane (
  input  logic valid,
  input  logic guard,
  input  logic pred,
  input  logic req,
  output logic we,
  output logic squashed
);
  assign we       = pcg_pkg::commit_ok(valid, guard, pred, req);
  assign squashed = pcg_pkg::cancelled(valid, guard, pred, req);
endmodule

// File: rtl/pcg_squash_ctr.sv
module pcg_squash_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (inc && !at_max) count <= count + 1'b1;
  end
endmodule

// File: rtl/predicated_commit_gate.sv
module predicated_commit_gate #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_wr_en,
  input  logic             pred_wr_val,
  input  logic             wb_valid,
  input  logic             wb_guard,
  input  logic             wb_rf_req,
  input  logic             wb_st_req,
  output logic             rf_we,
  output logic             st_we,
  output logic             pred_state,
  output logic [CNT_W-1:0] squash_count
);
  import pcg_pkg::*;

  // Named internal events, brought out for the checker
  logic                pred_eff;
  logic [NUM_WR-1:0]   lane_req;
  logic [NUM_WR-1:0]   lane_we;
  logic [NUM_WR-1:0]   lane_squash;
  logic                squash_evt;

  pcg_pred_reg u_pred (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pred_wr_en),
    .wr_val   (pred_wr_val),
    .pred_q   (pred_state),
    .pred_eff (pred_eff)
  );

  assign lane_req[WR_RF] = wb_rf_req;
  assign lane_req[WR_ST] = wb_st_req;

  for (genvar g = 0; g < NUM_WR; g++) begin : g_lane
    pcg_commit_lane u_lane (
      .valid    (wb_valid),
      .guard    (wb_guard),
      .pred     (pred_eff),
      .req      (lane_req[g]),
      .we       (lane_we[g]),
      .squashed (lane_squash[g])
    );
  end

  assign rf_we      = lane_we[WR_RF];
  assign st_we      = lane_we[WR_ST];
  assign squash_evt = |lane_squash;   // one count per commit, not per write

  pcg_squash_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (squash_evt),
    .count (squash_count)
  );
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_wr_en,
  input logic             pred_wr_val,
  input logic             wb_valid,
  input logic             wb_guard,
  input logic             wb_rf_req,
  input logic             wb_st_req,
  input logic             rf_we,
  input logic             st_we,
  input logic             pred_state,
  input logic [CNT_W-1:0] squash_count,
  input logic             pred_eff,
  input logic             squash_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_idle_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> (!rf_we && !st_we));

  assert_unguarded_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_guard) |-> (rf_we == wb_rf_req && st_we == wb_st_req));

  assert_guarded_rf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_guard && wb_rf_req) |-> (rf_we == pred_eff));

  assert_guarded_st_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_guard && wb_st_req) |-> (st_we == pred_eff));

  assert_bypass_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pred_wr_en |-> (pred_eff == pred_wr_val));

  assert_bypass_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_wr_en |-> (pred_eff == pred_state));

  assert_pred_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_wr_en |=> (pred_state == $past(pred_wr_val)));

  assert_pred_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_wr_en |=> $stable(pred_state));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_evt && squash_count != CNT_MAX) |=>
      (squash_count == CNT_W'($past(squash_count) + 1'b1)));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !squash_evt |=> $stable(squash_count));

  assert_count_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_count == CNT_MAX) |=> (squash_count == CNT_MAX));
endmodule

bind predicated_commit_gate pcg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pred_wr_en   (pred_wr_en),
  .pred_wr_val  (pred_wr_val),
  .wb_valid     (wb_valid),
  .wb_guard     (wb_guard),
  .wb_rf_req    (wb_rf_req),
  .wb_st_req    (wb_st_req),
  .rf_we        (rf_we),
  .st_we        (st_we),
  .pred_state   (pred_state),
  .squash_count (squash_count),
  .pred_eff     (pred_eff),
  .squash_evt   (squash_evt)
);

// File: tb/predicated_commit_gate_tb_top.sv
module predicated_commit_gate_tb_top;
  localparam int CNT_W   = 8;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_wr_en = 1'b0, pred_wr_val = 1'b0;
  logic wb_valid = 1'b0, wb_guard = 1'b0, wb_rf_req = 1'b0, wb_st_req = 1'b0;
  logic rf_we, st_we, pred_state;
  logic [CNT_W-1:0] squash_count;

  int errors = 0;
  int checks = 0;
  bit mdl_pred = 1'b0;
  int mdl_cnt  = 0;

  always #5 clk = ~clk;

  predicated_commit_gate #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pred_wr_en(pred_wr_en), .pred_wr_val(pred_wr_val),
    .wb_valid(wb_valid), .wb_guard(wb_guard),
    .wb_rf_req(wb_rf_req), .wb_st_req(wb_st_req),
    .rf_we(rf_we), .st_we(st_we),
    .pred_state(pred_state), .squash_count(squash_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One commit slot: drive, check the gated enables, then the registered state
  task automatic slot(input bit pe, input bit pv, input bit v, input bit g,
                      input bit rr, input bit sr);
    bit effp, exp_rf, exp_st, sup;
    string trf, tst;
    @(negedge clk);
    pred_wr_en = pe; pred_wr_val = pv;
    wb_valid = v; wb_guard = g; wb_rf_req = rr; wb_st_req = sr;
    #1;
    if (pe) effp = pv; else effp = mdl_pred;
    exp_rf = v && rr && (!g || effp);
    exp_st = v && sr && (!g || effp);
    if (!v)      begin trf = "R7"; tst = "R7"; end
    else if (!g) begin trf = "R3"; tst = "R3"; end
    else if (pe) begin trf = "R6"; tst = "R6"; end
    else         begin trf = "R4"; tst = "R5"; end
    chk({trf, " rf_we"}, int'(rf_we), int'(exp_rf));
    chk({tst, " st_we"}, int'(st_we), int'(exp_st));
    sup = v && g && !effp && (rr || sr);
    @(posedge clk);
    if (pe) mdl_pred = pv;
    if (sup && mdl_cnt < CNT_MAX) mdl_cnt++;
    #1;
    chk("R2 pred_state", int'(pred_state), int'(mdl_pred));
    chk(mdl_cnt == CNT_MAX ? "R9 squash_count" : "R8 squash_count",
        int'(squash_count), mdl_cnt);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pred_state in reset", int'(pred_state), 0);
    chk("R1 squash_count in reset", int'(squash_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pred_state after reset", int'(pred_state), 0);
    chk("R1 squash_count after reset", int'(squash_count), 0);

    // R3: unguarded commits ignore a false predicate
    slot(0, 0, 1, 0, 1, 1);
    // R4/R5: guarded with false predicate, both cancelled, counted once (R8)
    slot(0, 0, 1, 1, 1, 1);
    // R7: idle slot with requests does nothing
    slot(0, 0, 0, 1, 1, 1);
    slot(0, 0, 0, 0, 1, 0);
    // R6: compare writes true in same cycle as guarded commit
    slot(1, 1, 1, 1, 1, 0);
    // R2: predicate held true, guarded store commits
    slot(0, 0, 1, 1, 0, 1);
    // R6: same-cycle write to false cancels guarded commit
    slot(1, 0, 1, 1, 0, 1);
    // guarded, no request: no count (R8)
    slot(0, 0, 1, 1, 0, 0);
    // then/else pair: compare true, then arm runs, else arm cancelled
    slot(1, 1, 1, 0, 0, 0);
    slot(0, 0, 1, 1, 1, 0);
    slot(1, 0, 1, 1, 1, 1);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      slot(r[0], r[1], r[2] | r[5], r[3], r[4], r[5] ^ r[0]);
    end

    // R9: drive cancelled commits well past the saturation point
    slot(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < CNT_MAX + 20; i++) slot(0, 0, 1, 1, 1, 0);
    chk("R9 saturated", int'(squash_count), CNT_MAX);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule